// File: doc/BRIEF.md
# Half-Integer Clock Divider

This block derives a slower clock from an input clock by a ratio of D + 1.5, where D is a 5-bit unsigned setting. Each output period spans 2D + 3 half periods of the input clock. The output edges therefore land alternately on rising and falling input edges. Over every 2D + 3 input cycles the output completes exactly two periods, so its frequency is 2·f_in / (2D + 3). The smallest ratio, 1.5, comes from D = 0.

The design counts input cycles on the rising edge only. One such count window is one frame, and a frame holds two output periods. For each cycle the count decides whether the output toggles on the rising edge, on the falling edge that follows, or on both. One toggle flop is clocked on each input edge, and the output is the exclusive-or of the two flops. A single-cycle flag marks the input cycle in which each output rising edge occurs, which lets logic in the input clock domain follow the output phase.

The divisor is sampled only at a frame boundary, so a change never cuts a period short.

Top module: `hdiv_top`

## Requirements
- R1: The divisor input is a 5-bit unsigned value D. Every value from 0 to 31 is valid, and D = 31 gives the largest spacing between output rising edges, 65 half input periods.
- R2: With D held constant, consecutive rising edges of the output are exactly 2D + 3 half input periods apart.
- R3: Within each output period the output stays high for D + 1 half input periods and low for D + 2 half input periods.
- R4: Consecutive output rising edges alternate between input rising edges and input falling edges.
- R5: A new divisor value is taken only at a frame boundary, and a frame boundary is an output rising edge that falls on an input rising edge. Every output period is therefore a whole period of either the old or the new setting, and once the new setting appears the old one does not return.
- R6: While rstN is low, the output and the flag are low, independent of the clock. The first output rising edge occurs on the first input rising edge after reset is released.
- R7: The flag is high for the input cycle that contains each output rising edge, measured from the input rising edge at or before that output edge. It is low in cycles that contain no output rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clkIn | input | 1 | Input clock; both of its edges are used |
| rstN | input | 1 | Asynchronous reset, active low |
| divIn | input | 5 | Divisor setting D; the ratio is D + 1.5 |
| divClk | output | 1 | Divided clock output |
| riseFlag | output | 1 | High during the input cycle that holds an output rising edge |

## Verification
A wrong count, or a wrong toggle decision, changes the spacing or the duty of the output within one frame. A frame is at most 65 input cycles, so the fault shows as a period or high time that differs from 2D + 3 or D + 1 half periods. A divisor taken mid-frame shows up as a period that matches neither the old nor the new setting, and it appears in the first period after the change. A fault on the falling-edge path breaks the alternation of rising-edge phase on the very next odd-positioned edge.

// File: rtl/hdiv_pkg.sv
package hdiv_pkg;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic togEven;  // toggle output on the rising input edge that starts the cycle
    logic togOdd;   // toggle output on the falling input edge inside the cycle
    logic rise;     // an output rising edge occurs in the cycle
  } hdivStrobe_t;

endpackage

// File: rtl/hdiv_ctrl.sv
module hdiv_ctrl #(
  parameter int DIV_W = 5
) (
  input  logic                   clkIn,
  input  logic                   rstN,
  input  logic [DIV_W-1:0]       divIn,
  output hdiv_pkg::hdivStrobe_t  strobe
);

  localparam int CNT_W = DIV_W + 2;  // frame length up to 2*(2^W-1)+3 cycles
  localparam int PH_W  = DIV_W + 3;  // half-cycle positions within a frame

  logic             active;
  logic [CNT_W-1:0] cnt, cntNext, lastCnt;
  logic [DIV_W-1:0] dLat, dNext;
  logic             frameStart;
  logic [PH_W-1:0]  halfEven, halfOdd, dExt, firstFall, secondRise, secondFall;

  // A frame is 2D+3 input cycles, which holds two output periods
  assign lastCnt    = CNT_W'({dLat, 1'b0}) + CNT_W'(2);
  assign frameStart = !active || (cnt == lastCnt);
  assign cntNext    = frameStart ? '0 : cnt + CNT_W'(1);
  assign dNext      = frameStart ? divIn : dLat;

  // Half-cycle positions of the edges of the cycle about to start
  assign halfEven   = {cntNext, 1'b0};
  assign halfOdd    = halfEven + PH_W'(1);
  assign dExt       = PH_W'(dNext);
  assign firstFall  = dExt + PH_W'(1);
  assign secondRise = dExt + dExt + PH_W'(3);
  assign secondFall = dExt + dExt + dExt + PH_W'(4);

  always_comb begin
    strobe.togEven = (halfEven == '0) || (halfEven == firstFall) ||
                     (halfEven == secondFall);
    strobe.togOdd  = (halfOdd == firstFall) || (halfOdd == secondRise) ||
                     (halfOdd == secondFall);
    strobe.rise    = (halfEven == '0) || (halfOdd == secondRise);
  end

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
      dLat   <= '0;
    end else begin
      active <= 1'b1;
      cnt    <= cntNext;
      dLat   <= dNext;
    end
  end

  // R2: the cycle counter never runs past the end of its frame
  p_cnt_bound_r2: assert property (@(posedge clkIn) disable iff (!rstN)
    cnt <= lastCnt);

  // R5: the latched divisor moves only when a frame begins
  p_div_hold_r5: assert property (@(posedge clkIn) disable iff (!rstN)
    (cnt != '0) |-> $stable(dLat));

endmodule

// File: rtl/hdiv_path.sv
module hdiv_path (
  input  logic                  clkIn,
  input  logic                  rstN,
  input  hdiv_pkg::hdivStrobe_t strobe,
  output logic                  divClk,
  output logic                  riseFlag
);

  logic posTgl, negTgl, oddPend;

  always_ff @(posedge clkIn or negedge rstN) begin
    if (!rstN) begin
      posTgl   <= 1'b0;
      oddPend  <= 1'b0;
      riseFlag <= 1'b0;
    end else begin
      posTgl   <= posTgl ^ strobe.togEven;
      oddPend  <= strobe.togOdd;
      riseFlag <= strobe.rise;
    end
  end

  always_ff @(negedge clkIn or negedge rstN) begin
    if (!rstN) negTgl <= 1'b0;
    else if (oddPend) negTgl <= ~negTgl;
  end

  assign divClk = posTgl ^ negTgl;

  // R3: the output is low just before any cycle that holds a rising edge
  always @(posedge clkIn) begin
    if (rstN && strobe.rise)
      p_low_before_rise_r3: assert (divClk == 1'b0);
  end

  // R6: reset holds both outputs low
  always @(posedge clkIn) begin
    if (!rstN)
      p_reset_low_r6: assert (divClk == 1'b0 && riseFlag == 1'b0);
  end

endmodule

// File: rtl/hdiv_top.sv
module hdiv_top #(
  parameter int DIV_W = 5
) (
  input  logic             clkIn,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divIn,
  output logic             divClk,
  output logic             riseFlag
);

  hdiv_pkg::hdivStrobe_t strobe;

  hdiv_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clkIn  (clkIn),
    .rstN   (rstN),
    .divIn  (divIn),
    .strobe (strobe)
  );

  hdiv_path u_path (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .strobe   (strobe),
    .divClk   (divClk),
    .riseFlag (riseFlag)
  );

endmodule

// File: tb/sim_hdiv_top.sv
module sim_hdiv_top;

  localparam int CLK_PERIOD = 10;
  localparam int HALF = CLK_PERIOD / 2;

  logic       clkIn;
  logic       rstN;
  logic [4:0] divIn;
  logic       divClk;
  logic       riseFlag;

  int checks = 0;
  int errors = 0;

  hdiv_top u0 (
    .clkIn    (clkIn),
    .rstN     (rstN),
    .divIn    (divIn),
    .divClk   (divClk),
    .riseFlag (riseFlag)
  );

  initial begin
    clkIn = 1'b0;
    forever #(HALF) clkIn = ~clkIn;
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Rising edges of clkIn fall at odd multiples of HALF
  function automatic bit onPosedge(input time t);
    return (t % CLK_PERIOD) == HALF;
  endfunction

  task automatic testReset();
    time tRel, tRise;
    rstN  = 1'b0;
    divIn = 5'd2;
    repeat (4) @(negedge clkIn);
    #1;
    check(divClk == 1'b0, "R6", divClk, 0);
    check(riseFlag == 1'b0, "R6", riseFlag, 0);
    @(negedge clkIn);
    rstN = 1'b1;
    tRel = $time;
    @(posedge divClk);
    tRise = $time;
    check(tRise == tRel + HALF, "R6", tRise - tRel, HALF);
  endtask

  task automatic measure(input int d);
    time t0, t1, t2, t3, t4;
    longint per, hi;
    @(negedge clkIn);
    divIn = 5'(d);
    repeat (3) @(posedge divClk);
    per = longint'((2 * d + 3) * HALF);
    hi  = longint'((d + 1) * HALF);
    @(posedge divClk); t0 = $time;
    #1;
    check(riseFlag == 1'b1, "R7", riseFlag, 1);
    @(negedge divClk); t1 = $time;
    if (d >= 4) begin
      #(t0 + per - 16 - $time);
      check(riseFlag == 1'b0, "R7", riseFlag, 0);
    end
    @(posedge divClk); t2 = $time;
    @(negedge divClk); t3 = $time;
    @(posedge divClk); t4 = $time;
    check(longint'(t2 - t0) == per, (d == 0 || d == 31) ? "R1" : "R2", t2 - t0, per);
    check(longint'(t4 - t2) == per, "R2", t4 - t2, per);
    check(longint'(t1 - t0) == hi, "R3", t1 - t0, hi);
    check(longint'(t2 - t1) == per - hi, "R3", t2 - t1, per - hi);
    check(longint'(t3 - t2) == hi, "R3", t3 - t2, hi);
    check(onPosedge(t0) != onPosedge(t2), "R4", onPosedge(t2), !onPosedge(t0));
    check(onPosedge(t2) != onPosedge(t4), "R4", onPosedge(t4), !onPosedge(t2));
  endtask

  task automatic testChange();
    time tr [0:6];
    longint oldPer, newPer, p;
    bit seenNew, firstNewSeen;
    oldPer = longint'(43 * HALF);
    newPer = longint'(5 * HALF);
    @(negedge clkIn);
    divIn = 5'd20;
    repeat (4) @(posedge divClk);
    repeat (7) @(negedge clkIn);
    divIn = 5'd1;
    for (int i = 0; i < 7; i++) begin
      @(posedge divClk);
      tr[i] = $time;
    end
    seenNew = 1'b0;
    firstNewSeen = 1'b0;
    for (int i = 1; i < 7; i++) begin
      p = longint'(tr[i] - tr[i-1]);
      check(p == oldPer || p == newPer, "R5", p, newPer);
      if (p == newPer && !seenNew) begin
        firstNewSeen = 1'b1;
        check(onPosedge(tr[i-1]), "R5", tr[i-1] % CLK_PERIOD, HALF);
      end
      if (seenNew) check(p == newPer, "R5", p, newPer);
      if (p == newPer) seenNew = 1'b1;
    end
    check(firstNewSeen, "R5", firstNewSeen, 1);
  endtask

  task automatic testMidReset();
    @(negedge clkIn);
    divIn = 5'd6;
    repeat (3) @(posedge divClk);
    #2;
    rstN = 1'b0;
    #1;
    check(divClk == 1'b0, "R6", divClk, 0);
    check(riseFlag == 1'b0, "R6", riseFlag, 0);
    repeat (3) @(negedge clkIn);
    #1;
    check(divClk == 1'b0, "R6", divClk, 0);
    @(negedge clkIn);
    rstN = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    rstN  = 1'b0;
    divIn = '0;
    testReset();
    // R1: sweep every divisor setting
    for (int d = 0; d < 32; d++) measure(d);
    testChange();
    testMidReset();
    measure(3);
    measure(0);
    finishRun();
  end

endmodule